// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit turns one decoded operand specifier into either an immediate operand, a register number or a memory effective address. The specifier is a 4-bit mode code, a short address field, a register selector and the address of the next instruction. The unit reads one register-file port combinationally. Modes that need an indirection make a single memory read through a request/ready handshake. Modes that move an index or stack register return that register's new value as a one-cycle write-back request. This request appears in the same cycle as the result.

A caller pulses `start_i` while the unit is idle and then waits for `done_o`. Modes without a memory read finish on the edge after the edge that samples `start_i`. Modes with a read finish on the edge that samples `mem_ready_i` high. A mode code that is not assigned raises `illegal_o` for one cycle in place of `done_o`.

Top module: `ea_unit`

## Requirements
- R1: While reset is active, and right after it, `busy_o`, `done_o`, `illegal_o`, `mem_req_o` and `wb_en_o` are low.
- R2: Immediate (code 0) returns the address field sign-extended from its top bit to the word width. It sets `is_imm_o`, makes no memory request, and `done_o` rises on the edge after the one that samples `start_i`, for exactly one cycle.
- R3: Direct (code 1) returns the address field zero-extended as the address, with no memory request.
- R4: Register (code 3) returns the register selector as the result and sets `is_reg_o`.
- R5: Indirect (code 2) makes one read at the zero-extended field, and the returned word is the address. `done_o` rises on the edge that samples `mem_ready_i` high.
- R6: Register indirect (code 4) returns the contents of register R. Stack top (code 11) returns the contents of the stack-pointer register (index 15). Neither reads memory.
- R7: Displacement (code 5) gives sext(A)+(R). Base (code 7) gives sext(A) plus the segment-base register (index 14). PC-relative (code 6) gives the next-instruction address plus sext(A). All wrap modulo 2^width.
- R8: Autoindex (code 8) gives zext(A)+(R) and requests write-back of R+1, or of R-1 when `dec_i` is 1, together with `done_o`.
- R9: Pre-index (code 9) reads at zext(A)+(R) and returns the read word. Post-index (code 10) reads at zext(A) and returns the read word plus (R).
- R10: Push (code 12) returns SP-1 and writes back SP-1 to register 15. Pop (code 13) returns SP and writes back SP+1.
- R11: Codes 14 and 15 raise `illegal_o` for one cycle at the time `done_o` would rise. They produce no `done_o`, no memory request and no write-back.
- R12: `mem_req_o` and `mem_addr_o` stay unchanged until `mem_ready_i` is seen. At most one read is made per operation.
- R13: `start_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| mode_i | input | 4 | Addressing mode code |
| dec_i | input | 1 | Autoindex decrements instead of increments |
| afld_i | input | A_W | Address field A |
| rsel_i | input | REG_AW | Register selector R |
| pc_i | input | DATA_W | Address of the next instruction |
| rf_sel_o | output | REG_AW | Register-file read index |
| rf_data_i | input | DATA_W | Register-file read data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | DATA_W | Memory read address |
| mem_ready_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result valid (one cycle) |
| illegal_o | output | 1 | Unassigned mode code (one cycle) |
| result_o | output | DATA_W | Operand, address or register number |
| is_reg_o | output | 1 | Result is a register number |
| is_imm_o | output | 1 | Result is an immediate operand |
| wb_en_o | output | 1 | Register write-back request |
| wb_reg_o | output | REG_AW | Write-back register |
| wb_data_o | output | DATA_W | Write-back value |

## Verification
Each mode is tried with address fields that have the top bit set and clear. This separates sign extension from zero extension in the immediate, displacement and PC-relative paths. Pre-index and post-index run with the same A and R, so a swapped order of add and read gives a different read address and result. Memory latencies of zero to three wait cycles show whether done timing follows ready. A start pulse injected mid-read shows whether a busy unit accepts a new request.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam logic [3:0] M_IMM   = 4'd0;
  localparam logic [3:0] M_DIR   = 4'd1;
  localparam logic [3:0] M_IND   = 4'd2;
  localparam logic [3:0] M_REG   = 4'd3;
  localparam logic [3:0] M_RIND  = 4'd4;
  localparam logic [3:0] M_DISP  = 4'd5;
  localparam logic [3:0] M_PCREL = 4'd6;
  localparam logic [3:0] M_BASE  = 4'd7;
  localparam logic [3:0] M_AUTO  = 4'd8;
  localparam logic [3:0] M_PRE   = 4'd9;
  localparam logic [3:0] M_POST  = 4'd10;
  localparam logic [3:0] M_STK   = 4'd11;
  localparam logic [3:0] M_PUSH  = 4'd12;
  localparam logic [3:0] M_POP   = 4'd13;

  typedef enum logic [1:0] {RS_FIELD, RS_STACK, RS_SEG} rsrc_e;
  typedef enum logic [2:0] {OP_A, OP_REG, OP_A_REG, OP_PC_A, OP_REG_DEC, OP_REGNUM} op_e;
  typedef enum logic [1:0] {K_MEM, K_REG, K_IMM} kind_e;

  typedef struct packed {
    logic  legal;
    rsrc_e rsrc;
    logic  a_sx;
    op_e   op;
    logic  mem_rd;
    logic  post_add;
    kind_e kind;
    logic  wb;
    logic  wb_neg;
  } ctrl_t;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [3:0] mode_i,
  input  logic       dec_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o          = '0;
    ctrl_o.legal    = 1'b1;
    ctrl_o.rsrc     = RS_FIELD;
    ctrl_o.op       = OP_A;
    ctrl_o.kind     = K_MEM;
    unique case (mode_i)
      M_IMM:   begin ctrl_o.a_sx = 1'b1; ctrl_o.kind = K_IMM; end
      M_DIR:   ;
      M_IND:   ctrl_o.mem_rd = 1'b1;
      M_REG:   begin ctrl_o.op = OP_REGNUM; ctrl_o.kind = K_REG; end
      M_RIND:  ctrl_o.op = OP_REG;
      M_DISP:  begin ctrl_o.a_sx = 1'b1; ctrl_o.op = OP_A_REG; end
      M_PCREL: begin ctrl_o.a_sx = 1'b1; ctrl_o.op = OP_PC_A; end
      M_BASE:  begin ctrl_o.a_sx = 1'b1; ctrl_o.op = OP_A_REG; ctrl_o.rsrc = RS_SEG; end
      M_AUTO:  begin ctrl_o.op = OP_A_REG; ctrl_o.wb = 1'b1; ctrl_o.wb_neg = dec_i; end
      M_PRE:   begin ctrl_o.op = OP_A_REG; ctrl_o.mem_rd = 1'b1; end
      M_POST:  begin ctrl_o.mem_rd = 1'b1; ctrl_o.post_add = 1'b1; end
      M_STK:   begin ctrl_o.rsrc = RS_STACK; ctrl_o.op = OP_REG; end
      M_PUSH:  begin
        ctrl_o.rsrc = RS_STACK; ctrl_o.op = OP_REG_DEC;
        ctrl_o.wb = 1'b1; ctrl_o.wb_neg = 1'b1;
      end
      M_POP:   begin ctrl_o.rsrc = RS_STACK; ctrl_o.op = OP_REG; ctrl_o.wb = 1'b1; end
      default: ctrl_o.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int A_W    = 8,
  parameter int REG_AW = 4
) (
  input  ctrl_t              ctrl_i,
  input  logic [A_W-1:0]     afld_i,
  input  logic [REG_AW-1:0]  rsel_i,
  input  logic [DATA_W-1:0]  reg_val_i,
  input  logic [DATA_W-1:0]  pc_i,
  input  logic [DATA_W-1:0]  rdata_i,
  input  logic [DATA_W-1:0]  post_reg_i,
  output logic [DATA_W-1:0]  pre_val_o,
  output logic [DATA_W-1:0]  wb_val_o,
  output logic [DATA_W-1:0]  post_val_o
);
  localparam int EXT_W = DATA_W - A_W;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] a_ext;

  assign a_ext = ctrl_i.a_sx ? {{EXT_W{afld_i[A_W-1]}}, afld_i}
                             : {{EXT_W{1'b0}}, afld_i};

  always_comb begin
    unique case (ctrl_i.op)
      OP_A:       pre_val_o = a_ext;
      OP_REG:     pre_val_o = reg_val_i;
      OP_A_REG:   pre_val_o = a_ext + reg_val_i;
      OP_PC_A:    pre_val_o = pc_i + a_ext;
      OP_REG_DEC: pre_val_o = reg_val_i - ONE;
      OP_REGNUM:  pre_val_o = {{(DATA_W-REG_AW){1'b0}}, rsel_i};
      default:    pre_val_o = a_ext;
    endcase
  end

  assign wb_val_o   = ctrl_i.wb_neg ? reg_val_i - ONE : reg_val_i + ONE;
  assign post_val_o = ctrl_i.post_add ? rdata_i + post_reg_i : rdata_i;
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int A_W     = 8,
  parameter int REG_AW  = 4,
  parameter int SP_IDX  = 15,
  parameter int SEG_IDX = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        mode_i,
  input  logic              dec_i,
  input  logic [A_W-1:0]    afld_i,
  input  logic [REG_AW-1:0] rsel_i,
  input  logic [DATA_W-1:0] pc_i,
  output logic [REG_AW-1:0] rf_sel_o,
  input  logic [DATA_W-1:0] rf_data_i,
  output logic              mem_req_o,
  output logic [DATA_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] result_o,
  output logic              is_reg_o,
  output logic              is_imm_o,
  output logic              wb_en_o,
  output logic [REG_AW-1:0] wb_reg_o,
  output logic [DATA_W-1:0] wb_data_o
);
  localparam logic [REG_AW-1:0] SP_SEL  = REG_AW'(SP_IDX);
  localparam logic [REG_AW-1:0] SEG_SEL = REG_AW'(SEG_IDX);

  typedef enum logic [2:0] {S_IDLE, S_CALC, S_MEM, S_DONE, S_ILL} st_e;

  st_e               st_q;
  logic [3:0]        mode_q;
  logic              dec_q;
  logic [A_W-1:0]    afld_q;
  logic [REG_AW-1:0] rsel_q;
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] rval_q;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] res_q;
  kind_e             kind_q;
  logic              wb_q;
  logic [REG_AW-1:0] wb_reg_q;
  logic [DATA_W-1:0] wb_data_q;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] pre_val, wb_val, post_val;

  ea_decode u_dec (
    .mode_i (mode_q),
    .dec_i  (dec_q),
    .ctrl_o (ctrl)
  );

  ea_calc #(.DATA_W(DATA_W), .A_W(A_W), .REG_AW(REG_AW)) u_calc (
    .ctrl_i     (ctrl),
    .afld_i     (afld_q),
    .rsel_i     (rsel_q),
    .reg_val_i  (rf_data_i),
    .pc_i       (pc_q),
    .rdata_i    (mem_rdata_i),
    .post_reg_i (rval_q),
    .pre_val_o  (pre_val),
    .wb_val_o   (wb_val),
    .post_val_o (post_val)
  );

  always_comb begin
    unique case (ctrl.rsrc)
      RS_STACK: rf_sel_o = SP_SEL;
      RS_SEG:   rf_sel_o = SEG_SEL;
      default:  rf_sel_o = rsel_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      mode_q    <= '0;
      dec_q     <= 1'b0;
      afld_q    <= '0;
      rsel_q    <= '0;
      pc_q      <= '0;
      rval_q    <= '0;
      addr_q    <= '0;
      res_q     <= '0;
      kind_q    <= K_MEM;
      wb_q      <= 1'b0;
      wb_reg_q  <= '0;
      wb_data_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          mode_q <= mode_i;
          dec_q  <= dec_i;
          afld_q <= afld_i;
          rsel_q <= rsel_i;
          pc_q   <= pc_i;
          st_q   <= S_CALC;
        end
        S_CALC: begin
          if (!ctrl.legal) begin
            wb_q <= 1'b0;
            st_q <= S_ILL;
          end else begin
            rval_q    <= rf_data_i;
            kind_q    <= ctrl.kind;
            wb_q      <= ctrl.wb;
            wb_reg_q  <= rf_sel_o;
            wb_data_q <= wb_val;
            if (ctrl.mem_rd) begin
              addr_q <= pre_val;
              st_q   <= S_MEM;
            end else begin
              res_q <= pre_val;
              st_q  <= S_DONE;
            end
          end
        end
        S_MEM: if (mem_ready_i) begin
          res_q <= post_val;
          st_q  <= S_DONE;
        end
        S_DONE:  st_q <= S_IDLE;
        S_ILL:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = (st_q == S_DONE);
  assign illegal_o  = (st_q == S_ILL);
  assign mem_req_o  = (st_q == S_MEM);
  assign mem_addr_o = addr_q;
  assign result_o   = res_q;
  assign is_reg_o   = (kind_q == K_REG);
  assign is_imm_o   = (kind_q == K_IMM);
  assign wb_en_o    = done_o && wb_q;
  assign wb_reg_o   = wb_reg_q;
  assign wb_data_o  = wb_data_q;

  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));
  // R12
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  ill_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o && !done_o);
  // R8
  wb_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> done_o);
  // R13
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> !done_o && !illegal_o);
endmodule

// File: tb/ea_unit_bench.sv
module ea_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic        dec = 1'b0;
  logic [7:0]  afld = '0;
  logic [3:0]  rsel = '0;
  logic [15:0] pc = '0;
  logic [3:0]  rf_sel;
  logic [15:0] rf_data;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        busy, done, illegal, is_reg, is_imm, wb_en;
  logic [15:0] result, wb_data;
  logic [3:0]  wb_reg;

  logic [15:0] rf [16];
  int tests = 0, fails = 0, mem_dly = 0, wcnt = 0, grants = 0, cycles = 0;
  logic [15:0] seen_addr = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign rf_data = rf[rf_sel];

  ea_unit u_ea_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .dec_i(dec),
    .afld_i(afld), .rsel_i(rsel), .pc_i(pc), .rf_sel_o(rf_sel), .rf_data_i(rf_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .illegal_o(illegal),
    .result_o(result), .is_reg_o(is_reg), .is_imm_o(is_imm), .wb_en_o(wb_en),
    .wb_reg_o(wb_reg), .wb_data_o(wb_data)
  );

  function automatic logic [15:0] mem_fn(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] sx(input logic [7:0] a);
    return {{8{a[7]}}, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder, drives away from the rising edge
  always @(negedge clk) begin
    if (!mem_req) begin
      mem_ready = 1'b0;
      wcnt = 0;
    end else if (!mem_ready) begin
      if (wcnt == mem_dly) begin
        mem_ready = 1'b1;
        mem_rdata = mem_fn(mem_addr);
        seen_addr = mem_addr;
        grants++;
      end else wcnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run(input logic [3:0] m, input logic d, input logic [7:0] a,
                     input logic [3:0] r, input logic [15:0] p, input int dly,
                     input bit inject, input string req);
    logic [15:0] e_res = '0, e_maddr = '0, e_wdat = '0, rd;
    logic [3:0]  e_wreg = '0;
    int e_kind = 0, e_cyc, g0;
    bit e_mem = 0, e_wb = 0, e_ill = 0;
    case (m)
      4'd0:  begin e_res = sx(a); e_kind = 2; end
      4'd1:  e_res = {8'h00, a};
      4'd2:  begin e_mem = 1; e_maddr = {8'h00, a}; e_res = mem_fn(e_maddr); end
      4'd3:  begin e_res = {12'h000, r}; e_kind = 1; end
      4'd4:  e_res = rf[r];
      4'd5:  e_res = sx(a) + rf[r];
      4'd6:  e_res = p + sx(a);
      4'd7:  e_res = sx(a) + rf[14];
      4'd8:  begin e_res = {8'h00, a} + rf[r]; e_wb = 1; e_wreg = r;
                   e_wdat = d ? rf[r] - 16'd1 : rf[r] + 16'd1; end
      4'd9:  begin e_mem = 1; e_maddr = {8'h00, a} + rf[r]; e_res = mem_fn(e_maddr); end
      4'd10: begin e_mem = 1; e_maddr = {8'h00, a}; e_res = mem_fn(e_maddr) + rf[r]; end
      4'd11: e_res = rf[15];
      4'd12: begin e_res = rf[15] - 16'd1; e_wb = 1; e_wreg = 4'd15; e_wdat = rf[15] - 16'd1; end
      4'd13: begin e_res = rf[15]; e_wb = 1; e_wreg = 4'd15; e_wdat = rf[15] + 16'd1; end
      default: e_ill = 1;
    endcase
    e_cyc = e_mem ? 3 + dly : 2;
    mem_dly = dly;
    g0 = grants;
    start = 1'b1; mode = m; dec = d; afld = a; rsel = r; pc = p;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 1; cyc <= e_cyc + 2; cyc++) begin
      if (inject && cyc == 3) begin start = 1'b1; mode = 4'd0; afld = 8'h11; end
      else if (inject && cyc == 4) start = 1'b0;
      chk(done == (cyc == e_cyc && !e_ill), req, {15'd0, done}, {15'd0, cyc == e_cyc && !e_ill});
      chk(illegal == (cyc == e_cyc && e_ill), "R11", {15'd0, illegal}, {15'd0, cyc == e_cyc && e_ill});
      chk(busy == (cyc <= e_cyc), "R13", {15'd0, busy}, {15'd0, cyc <= e_cyc});
      if (cyc == e_cyc && !e_ill) begin
        chk(result == e_res, req, result, e_res);
        chk(is_reg == (e_kind == 1), "R4", {15'd0, is_reg}, {15'd0, e_kind == 1});
        chk(is_imm == (e_kind == 2), "R2", {15'd0, is_imm}, {15'd0, e_kind == 2});
        chk(wb_en == e_wb, "R8", {15'd0, wb_en}, {15'd0, e_wb});
        if (e_wb) begin
          chk(wb_reg == e_wreg, "R10", {12'd0, wb_reg}, {12'd0, e_wreg});
          chk(wb_data == e_wdat, "R8", wb_data, e_wdat);
        end
      end
      if (cyc == e_cyc && e_ill) chk(!wb_en, "R11", {15'd0, wb_en}, 16'd0);
      @(negedge clk);
    end
    rd = 16'(grants - g0);
    chk(rd == (e_mem ? 16'd1 : 16'd0), "R12", rd, e_mem ? 16'd1 : 16'd0);
    if (e_mem) chk(seen_addr == e_maddr, req, seen_addr, e_maddr);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 16'(i * 16'h0101 + 16'h0010);
    rf[6] = 16'hFFF0; rf[14] = 16'h4000; rf[15] = 16'h8000;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !illegal && !mem_req && !wb_en, "R1",
        {11'd0, busy, done, illegal, mem_req, wb_en}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R1", {13'd0, busy, done, mem_req}, 16'd0);
    run(4'd0,  0, 8'h85, 4'd0, 16'h0, 0, 0, "R2");
    run(4'd0,  0, 8'h7F, 4'd0, 16'h0, 0, 0, "R2");
    run(4'd1,  0, 8'h85, 4'd0, 16'h0, 0, 0, "R3");
    run(4'd3,  0, 8'h00, 4'd5, 16'h0, 0, 0, "R4");
    run(4'd2,  0, 8'h40, 4'd0, 16'h0, 0, 0, "R5");
    run(4'd2,  0, 8'hC1, 4'd0, 16'h0, 2, 0, "R5");
    run(4'd4,  0, 8'h00, 4'd3, 16'h0, 0, 0, "R6");
    run(4'd11, 0, 8'h00, 4'd3, 16'h0, 0, 0, "R6");
    run(4'd5,  0, 8'hF0, 4'd2, 16'h0, 0, 0, "R7");
    run(4'd5,  0, 8'h20, 4'd6, 16'h0, 0, 0, "R7");
    run(4'd6,  0, 8'hFE, 4'd0, 16'h1000, 0, 0, "R7");
    run(4'd6,  0, 8'h10, 4'd0, 16'h1000, 0, 0, "R7");
    run(4'd7,  0, 8'h85, 4'd2, 16'h0, 0, 0, "R7");
    run(4'd8,  0, 8'h85, 4'd4, 16'h0, 0, 0, "R8");
    run(4'd8,  1, 8'h05, 4'd4, 16'h0, 0, 0, "R8");
    run(4'd9,  0, 8'h10, 4'd1, 16'h0, 1, 0, "R9");
    run(4'd10, 0, 8'h10, 4'd1, 16'h0, 1, 0, "R9");
    run(4'd12, 0, 8'h00, 4'd0, 16'h0, 0, 0, "R10");
    run(4'd13, 0, 8'h00, 4'd0, 16'h0, 0, 0, "R10");
    run(4'd14, 0, 8'h10, 4'd1, 16'h0, 0, 0, "R11");
    run(4'd15, 0, 8'h10, 4'd1, 16'h0, 0, 0, "R11");
    run(4'd10, 0, 8'h33, 4'd7, 16'h0, 3, 1, "R13");
    run(4'd2,  0, 8'h77, 4'd0, 16'h0, 3, 0, "R12");
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule